// File: doc/BRIEF.md
# Network Statistics Counter Bank

This block keeps a set of frame-event counters for a network MAC. Each cycle the MAC may pulse any of seven event strobes: good receive frame, receive overrun, good transmit frame, transmit underrun, deferred transmit, CRC error and code error. Each strobe adds one to its own counter. The counters differ in width. The two frequent good-frame events get wide counters. Deferred transmits get a medium counter. The rare error events get narrow counters.

The counters are packed, zero-extended, into three 32-bit words. Software reads these words through a simple internal read port. A read returns the whole word one cycle later and clears every counter packed in that word in the same edge. The counters stop at their maximum value and do not wrap. While any counter has its top bit set, the bank holds an overflow interrupt request together with the interrupt type code for a statistics overflow. The host interrupt logic uses that request to schedule a read before the counter saturates.

Top module: `stat_bank`

## Requirements
- R1: After reset every counter is zero, `irq` is low, `irqCode` is 000 and `rdData` is zero.
- R2: Each cycle in which an event strobe is high adds exactly one to that event's counter. Strobes on several counters in the same cycle each count independently.
- R3: A read of byte address 0x30 returns the good-receive counter in bits 23:0 and the receive-overrun counter in bits 31:24. Each counter is zero-extended within its byte slot.
- R4: A read of byte address 0x34 returns the good-transmit counter in bits 23:0 and the transmit-underrun counter in bits 31:24.
- R5: A read of byte address 0x38 returns the deferred-transmit counter in bits 15:0, the CRC-error counter in bits 23:16 and the code-error counter in bits 31:24.
- R6: A read clears every counter in the word that was read, at the same clock edge that loads `rdData`. Counters in the other words keep their values.
- R7: When a strobe arrives in the same cycle as a read that clears its counter, the read returns the value from before the strobe, and the counter afterwards holds 1.
- R8: A counter at its maximum value (all ones at its width) stays at that value when further strobes arrive.
- R9: `irq` is high exactly when at least one counter has its most significant bit set. It stays high until every such counter has been read. `irqCode` is 010 while `irq` is high and 000 otherwise.
- R10: The read result appears on `rdData` one cycle after `rdEn`. A read of any address other than 0x30, 0x34 or 0x38 returns zero and clears nothing. Without a read, `rdData` keeps its last value. Address bits 1:0 of 0x30, 0x34 and 0x38 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evRxGood | input | 1 | Good receive frame strobe |
| evRxOverrun | input | 1 | Receive overrun strobe |
| evTxGood | input | 1 | Good transmit frame strobe |
| evTxUnderrun | input | 1 | Transmit underrun strobe |
| evTxDeferred | input | 1 | Deferred transmit strobe |
| evCrcErr | input | 1 | CRC error frame strobe |
| evCodeErr | input | 1 | Code error frame strobe |
| rdEn | input | 1 | Read request, one cycle |
| rdAddr | input | 8 | Byte address of the word to read |
| rdData | output | 32 | Packed word from the last read |
| irq | output | 1 | Statistics overflow request |
| irqCode | output | 3 | Interrupt type code, 010 while `irq` is high |

## Verification
The bench shrinks the counters to 6, 5 and 3 bits. For every counter it sweeps each event count from zero up to two past the maximum and reads the counter back after each count. This sweep separates correct counting from wrapping and from early or late saturation. It also shows the request rising at exactly half scale. A readback with all other fields zero exposes any slot that is misplaced or overlaps another.

Directed reads that arrive together with a strobe test the rule that the old value is returned and the counter restarts at one. Reads of unused addresses test that nothing is cleared. A pseudo-random phase then mixes strobes on all counters with reads to every address. This phase catches clears that reach the wrong word and counters that disturb one another.

// File: rtl/stat_pkg.sv
package stat_pkg;

  localparam int NUM_CNT   = 7;
  localparam int NUM_WORDS = 3;
  localparam int DATA_W    = 32;

  // counter indices
  localparam int C_RX_GOOD = 0;
  localparam int C_RX_OVR  = 1;
  localparam int C_TX_GOOD = 2;
  localparam int C_TX_UND  = 3;
  localparam int C_TX_DEF  = 4;
  localparam int C_CRC     = 5;
  localparam int C_CODE    = 6;

  // word that holds each counter (word 0 at the base address)
  function automatic int cntWord(input int idx);
    case (idx)
      C_RX_GOOD, C_RX_OVR: return 0;
      C_TX_GOOD, C_TX_UND: return 1;
      default:             return 2;
    endcase
  endfunction

  // lowest bit of each counter's slot inside its word
  function automatic int slotLsb(input int idx);
    case (idx)
      C_RX_OVR, C_TX_UND, C_CODE: return 24;
      C_CRC:                      return 16;
      default:                    return 0;
    endcase
  endfunction

  // slot class: 0 wide, 1 medium, 2 narrow
  function automatic int slotClass(input int idx);
    case (idx)
      C_RX_GOOD, C_TX_GOOD: return 0;
      C_TX_DEF:             return 1;
      default:              return 2;
    endcase
  endfunction

  typedef struct packed {
    logic               rdHit;   // read of a populated word
    logic               rdMiss;  // read of any other address
    logic [1:0]         rdWord;  // word index for rdHit
    logic [NUM_CNT-1:0] clr;     // per-counter clear strobes
  } ctrlStrb_t;

endpackage

// File: rtl/stat_counter.sv
module stat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ev,
  input  logic         clr,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (clr)       cnt <= ev ? W'(1) : '0;
    else if (ev && cnt != MAXV) cnt <= cnt + 1'b1;
  end

  // R2: an event below the maximum adds exactly one
  a_r2_increment: assert property (@(posedge clk) disable iff (rst)
    (ev && !clr && cnt != MAXV) |=> (cnt == $past(cnt) + 1'b1));

  // R8: a full counter stays full
  a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
    (!clr && cnt == MAXV) |=> (cnt == MAXV));

  // R6: a read clear without an event empties the counter
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && !ev) |=> (cnt == '0));

  // R7: a clear that coincides with an event restarts at one
  a_r7_restart: assert property (@(posedge clk) disable iff (rst)
    (clr && ev) |=> (cnt == W'(1)));

  // R2: no event and no clear leaves the value alone
  a_r2_idle: assert property (@(posedge clk) disable iff (rst)
    (!clr && !ev) |=> $stable(cnt));

endmodule

// File: rtl/stat_ctrl.sv
module stat_ctrl
  import stat_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output ctrlStrb_t         strb
);

  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_WORDS * 4);

  logic [ADDR_W-1:0] offs;
  logic              inRange;
  logic [1:0]        wordIdx;

  always_comb begin
    offs    = rdAddr - BASE_ADDR;
    inRange = (rdAddr >= BASE_ADDR) && (offs < SPAN);
    wordIdx = offs[3:2];
  end

  assign strb.rdHit  = rdEn && inRange;
  assign strb.rdMiss = rdEn && !inRange;
  assign strb.rdWord = wordIdx;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_clr
    localparam int WO = cntWord(i);
    assign strb.clr[i] = strb.rdHit && (wordIdx == WO[1:0]);
  end

  // R10: without a read, or on an unmapped address, nothing is cleared
  a_r10_no_clear: assert property (@(posedge clk) disable iff (rst)
    (!rdEn || rdAddr < BASE_ADDR || rdAddr >= BASE_ADDR + SPAN) |-> (strb.clr == '0));

  // R6: a read touches the counters of a single word
  a_r6_one_word: assert property (@(posedge clk) disable iff (rst)
    strb.rdHit |-> (strb.clr != '0));

endmodule

// File: rtl/stat_datapath.sv
module stat_datapath
  import stat_pkg::*;
#(
  parameter int WIDE_W   = 24,  // at most 24
  parameter int MID_W    = 16,  // at most 16
  parameter int NARROW_W = 8    // at most 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CNT-1:0] ev,
  input  ctrlStrb_t          strb,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq,
  output logic [2:0]         irqCode
);

  localparam logic [2:0] CODE_OVF = 3'b010;

  logic [23:0]       cntPad [NUM_CNT];
  logic [NUM_CNT-1:0] msb;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam int CW = (slotClass(i) == 0) ? WIDE_W :
                        (slotClass(i) == 1) ? MID_W : NARROW_W;
    logic [CW-1:0] cnt;

    stat_counter #(.W(CW)) i_cnt (
      .clk (clk),
      .rst (rst),
      .ev  (ev[i]),
      .clr (strb.clr[i]),
      .cnt (cnt)
    );

    assign cntPad[i] = 24'(cnt);
    assign msb[i]    = cnt[CW-1];
  end

  logic [DATA_W-1:0] wordVal [NUM_WORDS];

  always_comb begin
    for (int w = 0; w < NUM_WORDS; w++) wordVal[w] = '0;
    for (int i = 0; i < NUM_CNT; i++)
      wordVal[cntWord(i)] = wordVal[cntWord(i)] | (DATA_W'(cntPad[i]) << slotLsb(i));
  end

  logic [DATA_W-1:0] selWord;
  always_comb begin
    selWord = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (strb.rdWord == w[1:0]) selWord = wordVal[w];
  end

  always_ff @(posedge clk) begin
    if (rst)              rdData <= '0;
    else if (strb.rdHit)  rdData <= selWord;
    else if (strb.rdMiss) rdData <= '0;
  end

  assign irq     = |msb;
  assign irqCode = irq ? CODE_OVF : 3'b000;

  // R9: the request can only rise with an event
  a_r9_rise_on_event: assert property (@(posedge clk) disable iff (rst)
    (!irq && ev == '0) |=> !irq);

  // R9: the request can only fall with a clearing read
  a_r9_hold_until_read: assert property (@(posedge clk) disable iff (rst)
    (irq && strb.clr == '0) |=> irq);

  // R10: without a read the result is held
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!strb.rdHit && !strb.rdMiss) |=> $stable(rdData));

  // R10: an unmapped read returns zero
  a_r10_miss_zero: assert property (@(posedge clk) disable iff (rst)
    strb.rdMiss |=> (rdData == '0));

endmodule

// File: rtl/stat_bank.sv
module stat_bank
  import stat_pkg::*;
#(
  parameter int WIDE_W   = 24,
  parameter int MID_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        evRxGood,
  input  logic        evRxOverrun,
  input  logic        evTxGood,
  input  logic        evTxUnderrun,
  input  logic        evTxDeferred,
  input  logic        evCrcErr,
  input  logic        evCodeErr,
  input  logic        rdEn,
  input  logic [7:0]  rdAddr,
  output logic [31:0] rdData,
  output logic        irq,
  output logic [2:0]  irqCode
);

  logic [NUM_CNT-1:0] ev;
  ctrlStrb_t          strb;

  always_comb begin
    ev            = '0;
    ev[C_RX_GOOD] = evRxGood;
    ev[C_RX_OVR]  = evRxOverrun;
    ev[C_TX_GOOD] = evTxGood;
    ev[C_TX_UND]  = evTxUnderrun;
    ev[C_TX_DEF]  = evTxDeferred;
    ev[C_CRC]     = evCrcErr;
    ev[C_CODE]    = evCodeErr;
  end

  stat_ctrl #(.ADDR_W(8), .BASE_ADDR(8'h30)) i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .rdEn   (rdEn),
    .rdAddr (rdAddr),
    .strb   (strb)
  );

  stat_datapath #(.WIDE_W(WIDE_W), .MID_W(MID_W), .NARROW_W(NARROW_W)) i_dp (
    .clk     (clk),
    .rst     (rst),
    .ev      (ev),
    .strb    (strb),
    .rdData  (rdData),
    .irq     (irq),
    .irqCode (irqCode)
  );

endmodule

// File: tb/test_stat_bank.sv
`timescale 1ns/1ps
module test_stat_bank;

  localparam int WW = 6, MW = 5, NW = 3;

  logic clk = 0, rst = 1;
  logic evRxGood, evRxOverrun, evTxGood, evTxUnderrun, evTxDeferred, evCrcErr, evCodeErr;
  logic rdEn;
  logic [7:0] rdAddr;
  logic [31:0] rdData;
  logic irq;
  logic [2:0] irqCode;

  always #4 clk = ~clk;  // 125 MHz

  stat_bank #(.WIDE_W(WW), .MID_W(MW), .NARROW_W(NW)) i_stat_bank (
    .clk(clk), .rst(rst),
    .evRxGood(evRxGood), .evRxOverrun(evRxOverrun), .evTxGood(evTxGood),
    .evTxUnderrun(evTxUnderrun), .evTxDeferred(evTxDeferred),
    .evCrcErr(evCrcErr), .evCodeErr(evCodeErr),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .irq(irq), .irqCode(irqCode)
  );

  int errors = 0, checks = 0;
  int model [7];
  int widthOf [7] = '{WW, NW, WW, NW, MW, NW, NW};
  int wordOf  [7] = '{0, 0, 1, 1, 2, 2, 2};
  int lsbOf   [7] = '{0, 24, 0, 24, 0, 16, 24};
  logic [31:0] lastRd = 0;

  function automatic int maxOf(int i);  return (1 << widthOf[i]) - 1; endfunction
  function automatic int halfOf(int i); return 1 << (widthOf[i] - 1); endfunction

  function automatic int wordIdx(logic [7:0] a);
    if (a >= 8'h30 && a < 8'h3C) return (a - 8'h30) >> 2;
    return -1;
  endfunction

  function automatic logic [31:0] expWord(int w);
    logic [31:0] v = 0;
    for (int i = 0; i < 7; i++)
      if (wordOf[i] == w) v = v | (32'(model[i]) << lsbOf[i]);
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, check.
  task automatic cyc(logic [6:0] mask, logic rd, logic [7:0] addr, string tag);
    int w;
    logic [31:0] expRd;
    logic expIrq;
    {evCodeErr, evCrcErr, evTxDeferred, evTxUnderrun, evTxGood, evRxOverrun, evRxGood} = mask;
    rdEn = rd; rdAddr = addr;
    w = rd ? wordIdx(addr) : -1;
    expRd = rd ? ((w >= 0) ? expWord(w) : 32'h0) : lastRd;
    for (int i = 0; i < 7; i++) begin
      if (rd && w == wordOf[i]) model[i] = mask[i] ? 1 : 0;
      else if (mask[i] && model[i] < maxOf(i)) model[i]++;
    end
    @(negedge clk);
    check(tag, rdData, expRd);
    lastRd = expRd;
    expIrq = 0;
    for (int i = 0; i < 7; i++) if (model[i] >= halfOf(i)) expIrq = 1;
    check("R9 irq", {31'b0, irq}, {31'b0, expIrq});
    check("R9 irqCode", {29'b0, irqCode}, expIrq ? 32'd2 : 32'd0);
  endtask

  task automatic idle(); cyc(7'b0, 0, 8'h00, "R10 hold"); endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : main
    logic [15:0] lfsr;
    logic [7:0] addrs [5] = '{8'h30, 8'h34, 8'h38, 8'h3C, 8'h40};
    for (int i = 0; i < 7; i++) model[i] = 0;
    {evCodeErr, evCrcErr, evTxDeferred, evTxUnderrun, evTxGood, evRxOverrun, evRxGood} = 0;
    rdEn = 0; rdAddr = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rdData", rdData, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 irqCode", {29'b0, irqCode}, 0);
    rst = 0;
    cyc(0, 1, 8'h30, "R1 word0");
    cyc(0, 1, 8'h34, "R1 word1");
    cyc(0, 1, 8'h38, "R1 word2");

    // R2/R8 sweep per counter; readback checks R3/R4/R5 layout
    for (int k = 0; k < 7; k++) begin
      for (int n = 0; n <= maxOf(k) + 2; n++) begin
        for (int p = 0; p < n; p++) cyc(7'(1 << k), 0, 8'h00, "R2 hold");
        cyc(0, 1, 8'h30 + 8'(4 * wordOf[k]),
            n > maxOf(k) ? "R8 saturate" :
            wordOf[k] == 0 ? "R3 layout R2" : wordOf[k] == 1 ? "R4 layout R2" : "R5 layout R2");
      end
    end

    // R2 simultaneous strobes, R6 selective clear
    repeat (2) cyc(7'h7F, 0, 0, "R2 all");
    cyc(0, 1, 8'h34, "R6 read word1");
    cyc(0, 1, 8'h30, "R6 word0 kept");
    cyc(0, 1, 8'h38, "R6 word2 kept");

    // R7 coincident event and read
    repeat (5) cyc(7'b0000001, 0, 0, "R2 load");
    cyc(7'b0000001, 1, 8'h30, "R7 old value");
    cyc(0, 1, 8'h30, "R7 restart at one");
    repeat (3) cyc(7'b0100000, 0, 0, "R2 load");
    cyc(7'b0100000, 1, 8'h3A, "R7 old value word2");
    cyc(0, 1, 8'h38, "R7 restart word2");

    // R10 unmapped reads return zero and clear nothing
    repeat (2) cyc(7'h7F, 0, 0, "R2 load");
    cyc(0, 1, 8'h3C, "R10 unmapped 3C");
    idle();
    cyc(0, 1, 8'h40, "R10 unmapped 40");
    cyc(0, 1, 8'h2C, "R10 unmapped 2C");
    cyc(0, 1, 8'h31, "R10 low bits ignored R3");
    cyc(0, 1, 8'h37, "R10 low bits ignored R4");
    cyc(0, 1, 8'h38, "R5 word2");

    // R6 mixed random traffic
    lfsr = 16'hACE1;
    for (int t = 0; t < 600; t++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[6:0] & lfsr[13:7], lfsr[9:8] == 2'b00,
          addrs[lfsr[14:12] % 5], "R6 random");
    end
    idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule